// File: doc/BRIEF.md
# Parallel FPGA configuration loader

This block is the master side of an 8-bit slave parallel configuration port. A single `start_i` pulse begins a load. The block pulses the program line low and then waits for the device to clear its configuration memory: it watches the init line fall and then rise again, and it applies a cycle-count timeout to each of these steps. Once the port is selected, the block takes configuration bytes from a valid/ready stream and places each one on the data bus before it produces one rising edge of the configuration clock. The number of bytes in the load is given by `byte_count_i` at start.

While bytes are streaming, the block watches the device lines. A low init line is taken as a CRC failure. A high done line stops the stream early without error. A high busy line, when that check is enabled, holds off the next byte. Once streaming ends, the block deselects the port and keeps clocking 0xFF until both done and init are high. It then gives a fixed number of extra clocks and reports success.

Every failure returns the port pins to idle and latches a distinct error code. That code stays until the next start. The init, done and busy inputs pass through a two-flop synchronizer (`SYNC_STAGES` = 2) before any decision uses them. All limits are counted in `clk_i` cycles.

Top module: `fpga_par_cfg_loader`

## Requirements
- R1: After reset, `prog_b_o`, `cs_b_o`, `rdwr_b_o` and `cclk_o` are high, `data_o` is 0xFF, and `byte_ready_o`, `done_o`, `err_o` are 0 with `err_code_o` = 0.
- R2: A start in idle drives `prog_b_o` low for at least `PROG_CYC` cycles. It stays low until the synchronized init line has been seen low, and then `prog_b_o` returns high exactly once per load.
- R3: If init is not seen low within `INIT_LOW_TO` cycles of `prog_b_o` falling, the load aborts with `err_code_o` = 1.
- R4: After the program line is released, no byte is requested and `cs_b_o` stays high until init is seen high. If that takes `INIT_HIGH_TO` cycles, the load aborts with code 2.
- R5: `cs_b_o` and `rdwr_b_o` are low at every byte handshake and go high when the final clocking phase starts.
- R6: Each accepted byte appears on `data_o` while `cclk_o` is high. `cclk_o` then goes low for one cycle and rises with `data_o` unchanged, so there is exactly one rising edge per byte and the bytes keep their stream order.
- R7: `byte_ready_o` is high only while the port is selected and the block is waiting for a byte, and exactly `byte_count_i` bytes are accepted in a load that does not end early.
- R8: Init seen low while streaming aborts the load with code 3, and no further byte is accepted.
- R9: Done seen high while streaming stops the byte requests. With the busy check on, a done raised right after the Nth byte edge leaves exactly N bytes accepted, and the load then ends in success.
- R10: With `CHECK_BUSY` = 1, `byte_ready_o` is never high while the busy input is high. Busy held for `BUSY_TO` cycles after a byte edge aborts with code 4.
- R11: In the final phase `data_o` is 0xFF at every `cclk_o` rising edge. Counting from the edge on which done and init are first both seen high through the synchronizer (that edge excluded), exactly `EXTRA_CLKS` more rising edges occur, and then `done_o` goes high. A done raised right after a rising edge therefore sees `EXTRA_CLKS`+1 rising edges before `done_o`.
- R12: If done and init are not both seen high within `DONE_TO` cycles of the final phase starting, the load aborts with code 5.
- R13: On any abort, `prog_b_o`, `cs_b_o`, `rdwr_b_o` and `cclk_o` are high and `done_o` is 0. `done_o`, `err_o` and `err_code_o` hold until the next accepted start, which clears them. A start during a load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a load (taken in idle only) |
| byte_count_i | input | CNT_W | Number of bytes in the load, sampled at start |
| byte_data_i | input | 8 | Configuration byte |
| byte_valid_i | input | 1 | Byte stream valid |
| byte_ready_o | output | 1 | Byte stream ready |
| prog_b_o | output | 1 | Program line, active low |
| cs_b_o | output | 1 | Port select, active low |
| rdwr_b_o | output | 1 | Write strobe, low for write |
| cclk_o | output | 1 | Configuration clock |
| data_o | output | 8 | Configuration data bus |
| init_b_i | input | 1 | Device init line, low while clearing or on error |
| done_i | input | 1 | Device done line |
| busy_i | input | 1 | Device busy line |
| done_o | output | 1 | Load finished successfully |
| err_o | output | 1 | Load aborted |
| err_code_o | output | 3 | Abort cause: 1 init-fall timeout, 2 init-rise timeout, 3 CRC, 4 busy timeout, 5 done timeout |

## Verification
Most faults in the sequencer show up on the pins within one or two configuration clock periods. A missed or extra state makes a byte appear on the bus with no edge, or makes two edges for one byte. It can also make `byte_ready_o` rise while the port is deselected. A stale synchronizer decision shows up as an off-by-one in the count of accepted bytes after early done or a CRC error. Timer or extra-clock counters with wrong limits show up as a wrong abort code, or as the wrong number of rising edges between done and `done_o`. The bench models the device pins and compares the captured byte sequence, the edge counts and the abort codes with values it works out from the requirements.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_INIT,
    ST_SELECT,
    ST_FETCH,
    ST_LOAD,
    ST_LOW,
    ST_BUSY,
    ST_POST_HI,
    ST_POST_LO
  } cfg_state_e;

  typedef enum logic [2:0] {
    ERR_NONE         = 3'd0,
    ERR_INIT_ASSERT  = 3'd1,
    ERR_INIT_RELEASE = 3'd2,
    ERR_CRC          = 3'd3,
    ERR_BUSY         = 3'd4,
    ERR_DONE         = 3'd5
  } cfg_err_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_cycle_timer.sv
module cfg_cycle_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (cnt_q != {W{1'b1}}) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/fpga_par_cfg_loader.sv
module fpga_par_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned CNT_W        = 24,
  parameter int unsigned TMR_W        = 28,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned PROG_CYC     = 75,
  parameter int unsigned INIT_LOW_TO  = 125_000,
  parameter int unsigned INIT_HIGH_TO = 125_000_000,
  parameter int unsigned BUSY_TO      = 1_250_000,
  parameter int unsigned DONE_TO      = 50_000_000,
  parameter int unsigned EXTRA_CLKS   = 8,
  parameter bit          CHECK_BUSY   = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic [7:0]       byte_data_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic             prog_b_o,
  output logic             cs_b_o,
  output logic             rdwr_b_o,
  output logic             cclk_o,
  output logic [7:0]       data_o,
  input  logic             init_b_i,
  input  logic             done_i,
  input  logic             busy_i,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       err_code_o
);

  localparam int unsigned EXTRA_W = $clog2(EXTRA_CLKS + 1);
  localparam logic [TMR_W-1:0] PROG_LIM  = TMR_W'(PROG_CYC - 1);
  localparam logic [TMR_W-1:0] ILOW_LIM  = TMR_W'(INIT_LOW_TO);
  localparam logic [TMR_W-1:0] IHIGH_LIM = TMR_W'(INIT_HIGH_TO);
  localparam logic [TMR_W-1:0] BUSY_LIM  = TMR_W'(BUSY_TO);
  localparam logic [TMR_W-1:0] DONE_LIM  = TMR_W'(DONE_TO);
  localparam logic [TMR_W-1:0] SYNC_LIM  = TMR_W'(SYNC_STAGES);
  localparam logic [EXTRA_W-1:0] EXTRA_LIM = EXTRA_W'(EXTRA_CLKS);

  cfg_state_e state_q, state_d;
  cfg_err_e   err_d, err_code_q;

  logic             init_s, done_s, busy_s;
  logic [TMR_W-1:0] st_cnt, ph_cnt;
  logic             in_post_q;
  logic [CNT_W-1:0] remain_q;
  logic             seen_q;
  logic [EXTRA_W-1:0] extra_q;
  logic             hs, fail, succeed, seen_now;
  logic             prog_q, sel_q, cclk_q, done_q, err_q;
  logic [7:0]       data_q;

  cfg_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({init_b_i, done_i, busy_i}),
    .q_o    ({init_s, done_s, busy_s})
  );

  cfg_cycle_timer #(.W(TMR_W)) i_state_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .cnt_o  (st_cnt)
  );

  cfg_cycle_timer #(.W(TMR_W)) i_phase_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_post_q),
    .cnt_o  (ph_cnt)
  );

  assign in_post_q    = (state_q == ST_POST_HI) || (state_q == ST_POST_LO);
  assign seen_now     = seen_q || (done_s && init_s);
  assign byte_ready_o = (state_q == ST_FETCH) && !done_s && init_s && (remain_q != '0);

  always_comb begin
    state_d = state_q;
    err_d   = ERR_NONE;
    fail    = 1'b0;
    succeed = 1'b0;
    hs      = 1'b0;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_PROG;
      ST_PROG: begin
        if (st_cnt >= PROG_LIM && !init_s) state_d = ST_WAIT_INIT;
        else if (st_cnt >= ILOW_LIM) begin fail = 1'b1; err_d = ERR_INIT_ASSERT; end
      end
      ST_WAIT_INIT: begin
        if (init_s) state_d = ST_SELECT;
        else if (st_cnt >= IHIGH_LIM) begin fail = 1'b1; err_d = ERR_INIT_RELEASE; end
      end
      ST_SELECT:    state_d = ST_FETCH;
      ST_FETCH: begin
        // early done wins over a pending byte; init low mid-stream means CRC
        if (done_s) state_d = ST_POST_HI;
        else if (!init_s) begin fail = 1'b1; err_d = ERR_CRC; end
        else if (remain_q == '0) state_d = ST_POST_HI;
        else if (byte_valid_i) begin hs = 1'b1; state_d = ST_LOAD; end
      end
      ST_LOAD:      state_d = ST_LOW;
      ST_LOW:       state_d = CHECK_BUSY ? ST_BUSY : ST_FETCH;
      ST_BUSY: begin
        // hold at least the synchronizer depth so a fresh busy is visible
        if (st_cnt >= SYNC_LIM && !busy_s) state_d = ST_FETCH;
        else if (st_cnt >= BUSY_LIM) begin fail = 1'b1; err_d = ERR_BUSY; end
      end
      ST_POST_HI: begin
        if (seen_now && extra_q == EXTRA_LIM) succeed = 1'b1;
        else if (!seen_now && ph_cnt >= DONE_LIM) begin fail = 1'b1; err_d = ERR_DONE; end
        else state_d = ST_POST_LO;
      end
      ST_POST_LO:   state_d = ST_POST_HI;
      default:      state_d = ST_IDLE;
    endcase
    if (fail || succeed) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      remain_q   <= '0;
      seen_q     <= 1'b0;
      extra_q    <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      err_code_q <= ERR_NONE;
      data_q     <= 8'hFF;
      prog_q     <= 1'b1;
      sel_q      <= 1'b0;
      cclk_q     <= 1'b1;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        remain_q   <= byte_count_i;
        done_q     <= 1'b0;
        err_q      <= 1'b0;
        err_code_q <= ERR_NONE;
      end else if (hs) begin
        remain_q <= remain_q - 1'b1;
      end
      if (fail) begin
        err_q      <= 1'b1;
        err_code_q <= err_d;
      end
      if (succeed) done_q <= 1'b1;

      if (!in_post_q) begin
        seen_q  <= 1'b0;
        extra_q <= '0;
      end else begin
        if (state_q == ST_POST_HI && done_s && init_s) seen_q <= 1'b1;
        if (state_q == ST_POST_LO && seen_q) extra_q <= extra_q + 1'b1;
      end

      if (hs) data_q <= byte_data_i;
      else if (state_d inside {ST_IDLE, ST_POST_HI, ST_POST_LO}) data_q <= 8'hFF;

      prog_q <= (state_d != ST_PROG);
      sel_q  <= state_d inside {ST_SELECT, ST_FETCH, ST_LOAD, ST_LOW, ST_BUSY};
      cclk_q <= !(state_d inside {ST_LOW, ST_POST_LO});
    end
  end

  assign prog_b_o   = prog_q;
  assign cs_b_o     = !sel_q;
  assign rdwr_b_o   = !sel_q;
  assign cclk_o     = cclk_q;
  assign data_o     = data_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = err_code_q;

  // checker state: length of the current program pulse
  logic [TMR_W-1:0] prog_low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               prog_low_cnt <= '0;
    else if (prog_b_o)                         prog_low_cnt <= '0;
    else if (prog_low_cnt != {TMR_W{1'b1}})    prog_low_cnt <= prog_low_cnt + 1'b1;
  end

  assert_prog_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_b_o) |-> prog_low_cnt >= TMR_W'(PROG_CYC));

  assert_ready_selected_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> (!cs_b_o && !rdwr_b_o && prog_b_o && cclk_o));

  assert_data_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cclk_o |-> $stable(data_o));

  assert_post_ones_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cclk_o && cs_b_o) |-> data_o == 8'hFF);

  assert_busy_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CHECK_BUSY && state_q == ST_BUSY && busy_s) |=> !byte_ready_o);

  assert_abort_idle_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (prog_b_o && cs_b_o && rdwr_b_o && cclk_o && !done_o));

  assert_code_set_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_code_o != 3'd0);

  assert_status_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

endmodule

// File: tb/test_fpga_par_cfg_loader.sv
`timescale 1ns/1ps
module test_fpga_par_cfg_loader;

  localparam int PROG_CYC = 6;
  localparam int EXTRA    = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] byte_count_i = '0;
  logic [7:0]  byte_data_i = '0;
  logic        byte_valid_i = 1'b0;
  logic        byte_ready_o, prog_b_o, cs_b_o, rdwr_b_o, cclk_o;
  logic [7:0]  data_o;
  logic        init_b_i = 1'b1, done_i = 1'b0, busy_i = 1'b0;
  logic        done_o, err_o;
  logic [2:0]  err_code_o;

  always #2 clk = ~clk;

  fpga_par_cfg_loader #(
    .CNT_W(16), .TMR_W(16), .SYNC_STAGES(2), .PROG_CYC(PROG_CYC),
    .INIT_LOW_TO(20), .INIT_HIGH_TO(40), .BUSY_TO(30), .DONE_TO(200),
    .EXTRA_CLKS(EXTRA), .CHECK_BUSY(1'b1)
  ) i_fpga_par_cfg_loader (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .byte_count_i(byte_count_i),
    .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
    .prog_b_o(prog_b_o), .cs_b_o(cs_b_o), .rdwr_b_o(rdwr_b_o), .cclk_o(cclk_o),
    .data_o(data_o), .init_b_i(init_b_i), .done_i(done_i), .busy_i(busy_i),
    .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
  );

  int n_chk = 0, n_fail = 0;

  // device model configuration (written by tasks only)
  int m_init_assert = 1, m_init_delay = 5, m_crc_at = 0, m_done_at = 0;
  int m_post_done = 3, m_busy_hold = 0, m_busy_stuck = 0, m_src_len = 0;
  int req_seq = 0;

  // environment state (written by the environment process only)
  int seen_seq = 0;
  int stream_rises, post_rises, after_done, post_bad, busy_viol;
  int prog_falls, prog_run, prog_last, ready_cycles, cs_low_cycles, hs_cs_bad;
  int src_idx, rel, busy_cnt;
  bit crc_on, hs_pend, prev_cclk = 1'b1, prev_prog = 1'b1;
  logic [7:0] cap [0:31];

  function automatic logic [7:0] pat(int k);
    return 8'(8'h5A ^ (k * 29 + 3));
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (seen_seq != req_seq) begin
        seen_seq = req_seq;
        stream_rises = 0; post_rises = 0; after_done = 0; post_bad = 0;
        busy_viol = 0; prog_falls = 0; prog_run = 0; prog_last = 0;
        ready_cycles = 0; cs_low_cycles = 0; hs_cs_bad = 0; src_idx = 0;
        busy_cnt = 0; busy_i = 1'b0; hs_pend = 1'b0;
      end
      // byte source
      if (hs_pend) src_idx++;
      byte_valid_i = (src_idx < m_src_len);
      byte_data_i  = pat(src_idx);
      hs_pend = byte_valid_i && byte_ready_o;
      if (hs_pend && (cs_b_o || rdwr_b_o)) hs_cs_bad++;
      if (byte_ready_o) ready_cycles++;
      if (!cs_b_o) cs_low_cycles++;
      if (byte_ready_o && busy_i) busy_viol++;
      // program line
      if (!prog_b_o) begin
        if (prev_prog) prog_falls++;
        prog_run++;
        crc_on = 1'b0; rel = 0; done_i = 1'b0;
        init_b_i = m_init_assert ? 1'b0 : 1'b1;
      end else begin
        if (!prev_prog) prog_last = prog_run;
        prog_run = 0;
        if (crc_on) init_b_i = 1'b0;
        else if (!init_b_i) begin
          rel++;
          if (rel >= m_init_delay) init_b_i = 1'b1;
        end
      end
      prev_prog = prog_b_o;
      // busy
      if (busy_cnt > 0) begin
        busy_cnt--;
        if (busy_cnt == 0 && m_busy_stuck == 0) busy_i = 1'b0;
      end
      // configuration clock edges
      if (cclk_o && !prev_cclk) begin
        if (!cs_b_o) begin
          if (stream_rises < 32) cap[stream_rises] = data_o;
          stream_rises++;
          if (stream_rises == m_crc_at) begin crc_on = 1'b1; init_b_i = 1'b0; end
          if (stream_rises == m_done_at) done_i = 1'b1;
          if (m_busy_stuck != 0) busy_i = 1'b1;
          else if (m_busy_hold > 0) begin busy_i = 1'b1; busy_cnt = m_busy_hold; end
        end else begin
          post_rises++;
          if (data_o != 8'hFF) post_bad++;
          if (done_i) after_done++;
          if (post_rises == m_post_done) done_i = 1'b1;
        end
      end
      prev_cclk = cclk_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic configure(input int ia, input int idly, input int crc, input int dat,
                           input int pd, input int bh, input int bs, input int len);
    m_init_assert = ia; m_init_delay = idly; m_crc_at = crc; m_done_at = dat;
    m_post_done = pd; m_busy_hold = bh; m_busy_stuck = bs; m_src_len = len;
    req_seq++;
    @(negedge clk); @(negedge clk);
  endtask

  // runs one load; mid_start pulses start again after 4 byte edges
  task automatic do_load(input int cnt, input bit mid_start, output int cycles);
    bit pulsed = 1'b0;
    cycles = 0;
    byte_count_i = 16'(cnt);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!(done_o || err_o) && cycles < 20000) begin
      @(negedge clk);
      cycles++;
      start_i = mid_start && !pulsed && stream_rises >= 4;
      if (start_i) pulsed = 1'b1;
    end
    start_i = 1'b0;
    chk(cycles < 20000, "R13", "load finished", cycles, 0);
  endtask

  task automatic check_idle(input string req);
    chk(prog_b_o && cs_b_o && rdwr_b_o && cclk_o, req, "pins idle",
        int'({prog_b_o, cs_b_o, rdwr_b_o, cclk_o}), 15);
  endtask

  task automatic t_reset;
    chk(prog_b_o && cs_b_o && rdwr_b_o && cclk_o, "R1", "pins high after reset",
        int'({prog_b_o, cs_b_o, rdwr_b_o, cclk_o}), 15);
    chk(data_o == 8'hFF, "R1", "data after reset", data_o, 255);
    chk(!byte_ready_o && !done_o && !err_o && err_code_o == 0, "R1", "status after reset",
        int'({byte_ready_o, done_o, err_o, err_code_o}), 0);
  endtask

  task automatic t_normal;
    int cyc;
    configure(1, 5, 0, 0, 3, 0, 0, 10);
    do_load(10, 1'b1, cyc);
    chk(done_o && !err_o, "R11", "success status", int'({done_o, err_o}), 2);
    chk(prog_last >= PROG_CYC, "R2", "program pulse width", prog_last, PROG_CYC);
    chk(prog_falls == 1, "R13", "start during load ignored", prog_falls, 1);
    chk(src_idx == 10, "R7", "bytes accepted", src_idx, 10);
    chk(stream_rises == 10, "R6", "one edge per byte", stream_rises, 10);
    for (int k = 0; k < 10; k++)
      chk(cap[k] == pat(k), "R6", "captured byte order", cap[k], pat(k));
    chk(hs_cs_bad == 0, "R5", "handshakes while deselected", hs_cs_bad, 0);
    chk(post_bad == 0, "R11", "non-0xFF edges in final phase", post_bad, 0);
    chk(after_done == EXTRA + 1, "R11", "edges after done", after_done, EXTRA + 1);
    check_idle("R5");
  endtask

  task automatic t_busy;
    int cyc;
    configure(1, 5, 0, 0, 2, 6, 0, 5);
    do_load(5, 1'b0, cyc);
    chk(busy_viol == 0, "R10", "ready while busy", busy_viol, 0);
    chk(done_o && !err_o, "R10", "success with busy", int'({done_o, err_o}), 2);
    chk(src_idx == 5, "R7", "bytes accepted with busy", src_idx, 5);
    for (int k = 0; k < 5; k++)
      chk(cap[k] == pat(k), "R6", "byte order with busy", cap[k], pat(k));
  endtask

  task automatic t_busy_timeout;
    int cyc;
    configure(1, 5, 0, 0, 2, 0, 1, 6);
    do_load(6, 1'b0, cyc);
    chk(err_o && err_code_o == 3'd4, "R10", "busy timeout code", err_code_o, 4);
    chk(src_idx == 1, "R10", "bytes before busy timeout", src_idx, 1);
    check_idle("R13");
  endtask

  task automatic t_init_assert_timeout;
    int cyc;
    configure(0, 5, 0, 0, 2, 0, 0, 4);
    do_load(4, 1'b0, cyc);
    chk(err_o && err_code_o == 3'd1, "R3", "init fall timeout code", err_code_o, 1);
    chk(cs_low_cycles == 0, "R3", "port never selected", cs_low_cycles, 0);
    check_idle("R13");
  endtask

  task automatic t_init_release_timeout;
    int cyc;
    configure(1, 1000, 0, 0, 2, 0, 0, 4);
    do_load(4, 1'b0, cyc);
    chk(err_o && err_code_o == 3'd2, "R4", "init rise timeout code", err_code_o, 2);
    chk(ready_cycles == 0, "R4", "ready before init high", ready_cycles, 0);
    chk(cs_low_cycles == 0, "R4", "select before init high", cs_low_cycles, 0);
  endtask

  task automatic t_crc;
    int cyc;
    configure(1, 5, 2, 0, 2, 0, 0, 6);
    do_load(6, 1'b0, cyc);
    chk(err_o && err_code_o == 3'd3, "R8", "CRC code", err_code_o, 3);
    chk(src_idx == 2, "R8", "bytes accepted before CRC", src_idx, 2);
    chk(!done_o, "R13", "done low on abort", done_o, 0);
    check_idle("R8");
  endtask

  task automatic t_early_done;
    int cyc;
    configure(1, 5, 0, 3, 0, 0, 0, 8);
    do_load(8, 1'b0, cyc);
    chk(done_o && !err_o, "R9", "early done success", int'({done_o, err_o}), 2);
    chk(src_idx == 3, "R9", "bytes after early done", src_idx, 3);
  endtask

  task automatic t_done_timeout;
    int cyc;
    configure(1, 5, 0, 0, 0, 0, 0, 1);
    do_load(1, 1'b0, cyc);
    chk(err_o && err_code_o == 3'd5, "R12", "done timeout code", err_code_o, 5);
    repeat (5) @(negedge clk);
    chk(err_o && err_code_o == 3'd5, "R13", "error held", err_code_o, 5);
    configure(1, 5, 0, 0, 2, 0, 0, 2);
    do_load(2, 1'b0, cyc);
    chk(done_o && !err_o && err_code_o == 0, "R13", "status cleared by start",
        int'({done_o, err_o, err_code_o}), 16);
  endtask

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_busy();
    t_busy_timeout();
    t_init_assert_timeout();
    t_init_release_timeout();
    t_crc();
    t_early_done();
    t_done_timeout();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule